// File: doc/BRIEF.md
# Windowed Address Decoder with Upper-Bit Remap

This block sorts a 32-bit CPU address into one of several programmable address windows and raises a single target select for the window it falls in. Each window has a lower limit and an upper limit. Both are 12-bit page numbers that stand for address bits 31:20, so windows are sized in 1 MB steps. Windows built with a remap register also rewrite bits 31:20 of the outgoing address. Each window carries a 3-bit byte-lane swap attribute, and the block passes the winning window's value to the datapath that follows. An address that no window claims raises the out-of-range flag.

Software programs the windows through a plain single-cycle register port. The register address is formed as `{window index, register kind}`. A write lands on the next rising clock edge, and read data comes back combinationally. One global control bit chooses whether a write to a window's lower limit also copies that value into the window's remap register. The lookup path is purely combinational from `addr_in`, with no storage and no handshake. Every control and status pin is plain, so no back-pressure applies: the outputs follow the address in the same cycle.

Top module: `addr_window_decoder`

## Requirements
- R1: After reset, every window has lower limit 0xFFF, upper limit 0x000, swap 1 and remap 0, and the control bit is 0. As a result, every address misses.
- R2: An address hits window i when addr[31:20] >= lower_i and addr[31:20] <= upper_i. The upper limit is inclusive, so upper_i concatenated with 20 one bits still hits, while the next page up does not.
- R3: A window whose upper limit is below its lower limit matches no address.
- R4: When several windows match, only the lowest-numbered one is flagged. `win_hit` always has at most one bit set.
- R5: When no window matches, `addr_miss` is 1, `win_hit` is 0 and `addr_out` equals `addr_in`.
- R6: On a hit in a window that has a remap register, addr_out[31:20] equals that register and addr_out[19:0] equals addr_in[19:0].
- R7: A window built without a remap register passes the address through unchanged on a hit. Its remap register reads 0, and writes to it are ignored.
- R8: While control bit 0 is 0, a write to a window's lower limit also copies wdata[11:0] into that window's remap register.
- R9: While control bit 0 is 1, a write to a lower limit leaves the remap register unchanged.
- R10: The lower-limit register stores the swap field from wdata[26:24]. Swap codes are: 0 byte swap, 1 no swap, 2 byte and word swap, 3 word swap, 4 to 7 reserved. On a hit, `hit_swap` shows the winning window's code; on a miss it shows 1. A read of the lower-limit register returns the limit in bits 11:0 and the swap field in bits 26:24, with all other bits 0.
- R11: A register write takes effect on the rising edge where `cfg_we` is sampled high. Before that edge, the decode outputs still reflect the old value.
- R12: The register address is cfg_addr = {index[2:0], kind[1:0]}, where kind 0 is the lower limit, 1 the upper limit, 2 remap and 3 control (any index). Upper and remap read back in bits 11:0, control in bit 0, and all other read bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 5 | Register address {window index, kind} |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data (combinational) |
| addr_in | input | 32 | CPU address to decode |
| win_hit | output | 8 | One-hot winning window |
| addr_miss | output | 1 | No window matched |
| addr_out | output | 32 | Address with bits 31:20 remapped on a hit |
| hit_swap | output | 3 | Swap code of the winning window |

## Verification
The hardest situation to reach is several live windows overlapping at the same address while their remap registers hold values that differ from their lower limits. Reaching it needs the control bit turned on between lower-limit writes and explicit remap writes. The random phase draws all limits, remap values and addresses from a small 32-page range, so overlaps, inverted windows and exact edge pages occur often. It also toggles the control bit at random and makes reserved-bit-laden writes, and it interleaves address probes with register readback against a bench model.

// File: rtl/addr_win_pkg.sv
`timescale 1ns/1ps
package addr_win_pkg;
  typedef enum logic [1:0] {
    REG_LOWER = 2'd0,
    REG_UPPER = 2'd1,
    REG_REMAP = 2'd2,
    REG_CTRL  = 2'd3
  } reg_kind_e;

  typedef enum logic [2:0] {
    SWAP_BYTE      = 3'd0,
    SWAP_NONE      = 3'd1,
    SWAP_BYTE_WORD = 3'd2,
    SWAP_WORD      = 3'd3
  } swap_mode_e;
endpackage

// File: rtl/win_regfile.sv
`timescale 1ns/1ps
module win_regfile
  import addr_win_pkg::*;
#(
  parameter int NUM_WIN  = 8,
  parameter int LIM_W    = 12,
  parameter int DATA_W   = 32,
  parameter int SWAP_LSB = 24,
  parameter int SWAP_W   = 3,
  parameter logic [NUM_WIN-1:0] HAS_REMAP = '1,
  localparam int IDX_W   = $clog2(NUM_WIN),
  localparam int CFG_AW  = IDX_W + 2
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            cfg_we,
  input  logic [CFG_AW-1:0]               cfg_addr,
  input  logic [DATA_W-1:0]               cfg_wdata,
  output logic [DATA_W-1:0]               cfg_rdata,
  output logic [NUM_WIN-1:0][LIM_W-1:0]   lower_o,
  output logic [NUM_WIN-1:0][LIM_W-1:0]   upper_o,
  output logic [NUM_WIN-1:0][LIM_W-1:0]   remap_o,
  output logic [NUM_WIN-1:0][SWAP_W-1:0]  swap_o
);
  logic [IDX_W-1:0] idx;
  reg_kind_e        kind;
  logic             remap_wr_dis;
  logic             unused_wdata;

  assign idx          = cfg_addr[CFG_AW-1:2];
  assign kind         = reg_kind_e'(cfg_addr[1:0]);
  assign unused_wdata = ^cfg_wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        remap_wr_dis <= 1'b0;
    else if (cfg_we && kind == REG_CTRL) remap_wr_dis <= cfg_wdata[0];
  end

  for (genvar i = 0; i < NUM_WIN; i++) begin : g_win
    logic sel;
    assign sel = cfg_we && (idx == IDX_W'(i));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        lower_o[i] <= '1;
        upper_o[i] <= '0;
        swap_o[i]  <= SWAP_W'(SWAP_NONE);
      end else begin
        if (sel && kind == REG_LOWER) begin
          lower_o[i] <= cfg_wdata[LIM_W-1:0];
          swap_o[i]  <= cfg_wdata[SWAP_LSB +: SWAP_W];
        end
        if (sel && kind == REG_UPPER) upper_o[i] <= cfg_wdata[LIM_W-1:0];
      end
    end

    if (HAS_REMAP[i]) begin : g_remap
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
          remap_o[i] <= '0;
        else if (sel && kind == REG_REMAP)
          remap_o[i] <= cfg_wdata[LIM_W-1:0];
        else if (sel && kind == REG_LOWER && !remap_wr_dis)
          remap_o[i] <= cfg_wdata[LIM_W-1:0];
      end
    end else begin : g_noremap
      assign remap_o[i] = '0;
    end
  end

  always_comb begin
    cfg_rdata = '0;
    if (kind == REG_CTRL) begin
      cfg_rdata[0] = remap_wr_dis;
    end else if (int'(idx) < NUM_WIN) begin
      case (kind)
        REG_LOWER: begin
          cfg_rdata[LIM_W-1:0]           = lower_o[idx];
          cfg_rdata[SWAP_LSB +: SWAP_W]  = swap_o[idx];
        end
        REG_UPPER: cfg_rdata[LIM_W-1:0] = upper_o[idx];
        REG_REMAP: cfg_rdata[LIM_W-1:0] = remap_o[idx];
        default:   cfg_rdata = '0;
      endcase
    end
  end

  // R8: a lower-limit write copies into remap while copying is enabled
  assert_remap_follow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && kind == REG_LOWER && !remap_wr_dis && HAS_REMAP[idx])
      |=> remap_o[$past(idx)] == $past(cfg_wdata[LIM_W-1:0]));

  // R9: with copying disabled the remap register holds
  assert_remap_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && kind == REG_LOWER && remap_wr_dis)
      |=> remap_o[$past(idx)] == $past(remap_o[idx]));
endmodule

// File: rtl/win_match.sv
`timescale 1ns/1ps
module win_match #(
  parameter int NUM_WIN = 8,
  parameter int LIM_W   = 12
) (
  input  logic [LIM_W-1:0]              page,
  input  logic [NUM_WIN-1:0][LIM_W-1:0] lower,
  input  logic [NUM_WIN-1:0][LIM_W-1:0] upper,
  output logic [NUM_WIN-1:0]            match
);
  for (genvar i = 0; i < NUM_WIN; i++) begin : g_cmp
    assign match[i] = (page >= lower[i]) && (page <= upper[i]);
  end
endmodule

// File: rtl/win_priority.sv
`timescale 1ns/1ps
module win_priority #(
  parameter int NUM_WIN = 8
) (
  input  logic [NUM_WIN-1:0] match,
  output logic [NUM_WIN-1:0] hit,
  output logic               any
);
  assign hit = match & (~match + NUM_WIN'(1));
  assign any = |match;
endmodule

// File: rtl/addr_window_decoder.sv
`timescale 1ns/1ps
module addr_window_decoder
  import addr_win_pkg::*;
#(
  parameter int NUM_WIN  = 8,
  parameter int ADDR_W   = 32,
  parameter int LIM_W    = 12,
  parameter int DATA_W   = 32,
  parameter int SWAP_LSB = 24,
  parameter int SWAP_W   = 3,
  parameter logic [NUM_WIN-1:0] HAS_REMAP = 8'h3F,
  localparam int IDX_W    = $clog2(NUM_WIN),
  localparam int CFG_AW   = IDX_W + 2,
  localparam int PAGE_LSB = ADDR_W - LIM_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_we,
  input  logic [CFG_AW-1:0]  cfg_addr,
  input  logic [DATA_W-1:0]  cfg_wdata,
  output logic [DATA_W-1:0]  cfg_rdata,
  input  logic [ADDR_W-1:0]  addr_in,
  output logic [NUM_WIN-1:0] win_hit,
  output logic               addr_miss,
  output logic [ADDR_W-1:0]  addr_out,
  output logic [SWAP_W-1:0]  hit_swap
);
  logic [NUM_WIN-1:0][LIM_W-1:0]  lower_q, upper_q, remap_q;
  logic [NUM_WIN-1:0][SWAP_W-1:0] swap_q;
  logic [NUM_WIN-1:0]             match;
  logic                           any_match;

  win_regfile #(
    .NUM_WIN(NUM_WIN), .LIM_W(LIM_W), .DATA_W(DATA_W),
    .SWAP_LSB(SWAP_LSB), .SWAP_W(SWAP_W), .HAS_REMAP(HAS_REMAP)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .lower_o(lower_q), .upper_o(upper_q), .remap_o(remap_q), .swap_o(swap_q)
  );

  win_match #(.NUM_WIN(NUM_WIN), .LIM_W(LIM_W)) u_match (
    .page(addr_in[ADDR_W-1:PAGE_LSB]), .lower(lower_q), .upper(upper_q),
    .match(match)
  );

  win_priority #(.NUM_WIN(NUM_WIN)) u_prio (
    .match(match), .hit(win_hit), .any(any_match)
  );

  assign addr_miss = ~any_match;

  always_comb begin
    addr_out = addr_in;
    hit_swap = SWAP_W'(SWAP_NONE);
    for (int i = 0; i < NUM_WIN; i++) begin
      if (win_hit[i]) begin
        if (HAS_REMAP[i]) addr_out[ADDR_W-1:PAGE_LSB] = remap_q[i];
        hit_swap = swap_q[i];
      end
    end
  end

  // R4: at most one window flagged
  assert_onehot_hit_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(win_hit));

  // R5: a miss forwards the address untouched and flags nothing
  assert_miss_pass_R5: assert property (@(posedge clk) disable iff (!rst_n)
    addr_miss |-> (addr_out == addr_in && win_hit == '0));

  // R6: offset within the 1 MB page is never altered
  assert_offset_kept_R6: assert property (@(posedge clk) disable iff (!rst_n)
    addr_out[PAGE_LSB-1:0] == addr_in[PAGE_LSB-1:0]);

  // R10: a miss reports the no-swap code
  assert_miss_swap_R10: assert property (@(posedge clk) disable iff (!rst_n)
    addr_miss |-> hit_swap == SWAP_W'(SWAP_NONE));
endmodule

// File: tb/addr_window_decoder_test.sv
`timescale 1ns/1ps
module addr_window_decoder_test;
  localparam int NW = 8;
  localparam logic [NW-1:0] REMAP_SET = 8'h3F;
  localparam logic [1:0] K_LO = 2'd0, K_UP = 2'd1, K_RM = 2'd2, K_CT = 2'd3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [4:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic [31:0] addr_in = '0;
  logic [7:0]  win_hit;
  logic        addr_miss;
  logic [31:0] addr_out;
  logic [2:0]  hit_swap;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  logic [11:0] m_lo [NW];
  logic [11:0] m_up [NW];
  logic [11:0] m_rm [NW];
  logic [2:0]  m_sw [NW];
  logic        m_dis;

  always #5 clk = ~clk;

  addr_window_decoder #(.HAS_REMAP(REMAP_SET)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .addr_in(addr_in),
    .win_hit(win_hit), .addr_miss(addr_miss), .addr_out(addr_out),
    .hit_swap(hit_swap)
  );

  function automatic int exp_win(logic [31:0] a);
    for (int i = 0; i < NW; i++)
      if (a[31:20] >= m_lo[i] && a[31:20] <= m_up[i]) return i;
    return -1;
  endfunction

  function automatic logic [31:0] exp_xlat(logic [31:0] a);
    int w = exp_win(a);
    if (w >= 0 && REMAP_SET[w]) return {m_rm[w], a[19:0]};
    return a;
  endfunction

  function automatic logic [31:0] exp_rd(int idx, logic [1:0] k);
    logic [31:0] r = '0;
    case (k)
      K_LO: begin r[11:0] = m_lo[idx]; r[26:24] = m_sw[idx]; end
      K_UP: r[11:0] = m_up[idx];
      K_RM: r[11:0] = REMAP_SET[idx] ? m_rm[idx] : 12'h0;
      default: r[0] = m_dis;
    endcase
    return r;
  endfunction

  task automatic check(bit ok, string req, string what,
                       logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic model_write(int idx, logic [1:0] k, logic [31:0] d);
    case (k)
      K_LO: begin
        m_lo[idx] = d[11:0]; m_sw[idx] = d[26:24];
        if (!m_dis && REMAP_SET[idx]) m_rm[idx] = d[11:0];
      end
      K_UP: m_up[idx] = d[11:0];
      K_RM: if (REMAP_SET[idx]) m_rm[idx] = d[11:0];
      default: m_dis = d[0];
    endcase
  endtask

  task automatic wr(int idx, logic [1:0] k, logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = {3'(idx), k}; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
    model_write(idx, k, d);
  endtask

  task automatic chk_addr(logic [31:0] a, string req);
    int w;
    logic [7:0] eh;
    addr_in = a;
    #1;
    w  = exp_win(a);
    eh = (w >= 0) ? 8'(1 << w) : 8'h0;
    check(win_hit == eh, req, "win_hit", 32'(win_hit), 32'(eh));
    check(addr_miss == (w < 0), req, "addr_miss", 32'(addr_miss), 32'(w < 0));
    check(addr_out == exp_xlat(a), req, "addr_out", addr_out, exp_xlat(a));
    check(hit_swap == ((w >= 0) ? m_sw[w] : 3'd1), req, "hit_swap",
          32'(hit_swap), 32'((w >= 0) ? m_sw[w] : 3'd1));
  endtask

  task automatic chk_reg(int idx, logic [1:0] k, string req);
    cfg_addr = {3'(idx), k};
    #1;
    check(cfg_rdata == exp_rd(idx, k), req, "cfg_rdata", cfg_rdata, exp_rd(idx, k));
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    for (int i = 0; i < NW; i++) begin
      m_lo[i] = 12'hFFF; m_up[i] = 12'h000; m_rm[i] = 12'h000; m_sw[i] = 3'd1;
    end
    m_dis = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    chk_addr(32'h0000_0000, "R1");
    chk_addr(32'hFFFF_FFFF, "R1");
    chk_addr(32'h8012_3456, "R1");
    for (int i = 0; i < NW; i++) begin
      chk_reg(i, K_LO, "R1"); chk_reg(i, K_UP, "R1"); chk_reg(i, K_RM, "R1");
    end
    chk_reg(0, K_CT, "R1");

    // R11: write lands at the edge, not before
    wr(7, K_UP, 32'h0000_07FF);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = {3'd7, K_LO}; cfg_wdata = 32'h0000_0700;
    addr_in = 32'h7000_0000;
    #1;
    check(addr_miss == 1'b1, "R11", "before edge", 32'(addr_miss), 32'd1);
    @(negedge clk);
    cfg_we = 1'b0;
    model_write(7, K_LO, 32'h0000_0700);
    chk_addr(32'h7000_0000, "R11");

    // R2: inclusive upper, edges; R6 remap of window 2 via copy (R8)
    wr(2, K_LO, 32'h0000_0100);
    wr(2, K_UP, 32'h0000_01FF);
    chk_reg(2, K_RM, "R8");
    chk_addr(32'h0FFF_FFFF, "R2");
    chk_addr(32'h1000_0000, "R2");
    chk_addr(32'h1FFF_FFFF, "R2");
    chk_addr(32'h2000_0000, "R2");
    wr(2, K_RM, 32'h0000_0ABC);
    chk_addr(32'h1234_5678, "R6");

    // R3: inverted window
    wr(3, K_LO, 32'h0000_0500);
    wr(3, K_UP, 32'h0000_04FF);
    chk_addr(32'h4FF0_0000, "R3");
    chk_addr(32'h5000_0000, "R3");

    // R4: overlap, lowest wins
    wr(1, K_LO, 32'h0000_0000);
    wr(1, K_UP, 32'h0000_08FF);
    chk_addr(32'h1800_0001, "R4");
    chk_addr(32'h7100_0000, "R4");

    // R5: miss above everything
    chk_addr(32'hF000_1234, "R5");

    // R9: copy disabled
    wr(0, K_CT, 32'h0000_0001);
    chk_reg(5, K_CT, "R12");
    wr(0, K_RM, 32'h0000_0123);
    wr(0, K_LO, 32'h0000_0C00);
    chk_reg(0, K_RM, "R9");
    wr(0, K_CT, 32'h0000_0000);

    // R7: window without remap
    wr(6, K_RM, 32'h0000_0555);
    chk_reg(6, K_RM, "R7");
    wr(6, K_LO, 32'h0300_0A00);
    wr(6, K_UP, 32'h0000_0AFF);
    chk_addr(32'hA123_4567, "R7");

    // R10: swap field and reserved bits on readback
    wr(4, K_LO, 32'hF3FF_FB00);
    wr(4, K_UP, 32'hFFFF_FBFF);
    chk_reg(4, K_LO, "R10");
    chk_reg(4, K_UP, "R12");
    chk_addr(32'hB00F_0000, "R10");

    // Random phase: small page range forces overlaps and edges
    for (int n = 0; n < 400; n++) begin
      int idx;
      logic [1:0] k;
      logic [31:0] d;
      idx = int'($urandom_range(0, NW-1));
      k   = 2'($urandom_range(0, 3));
      d   = $urandom;
      d[11:0] = 12'($urandom_range(0, 31));
      if (k == K_CT) d[0] = ($urandom_range(0, 3) == 0);
      wr(idx, k, d);
      for (int j = 0; j < 4; j++) begin
        logic [31:0] a;
        a = $urandom;
        a[31:20] = 12'($urandom_range(0, 33));
        if (j == 0) a[19:0] = '1;
        if (j == 1) a[19:0] = '0;
        chk_addr(a, "R4");
      end
      chk_reg(int'($urandom_range(0, NW-1)), 2'($urandom_range(0, 3)), "R12");
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule